// File: doc/BRIEF.md
# Vector Mask Compress Unit

This unit gathers the selected elements of a vector register group and packs them into the lowest element slots of a destination group. The order of the elements is kept. A separate mask register picks which source elements are selected. Its bits are spread apart by a mask-element spacing of 2^mlen_log2 bit positions. The unit takes a one-cycle start pulse. With that pulse it captures:

- the source group,
- the mask register,
- the previous destination contents,
- the active length,
- the element width,
- the mask spacing,
- the three register numbers used for the legality check.

The unit visits one element index per cycle. It writes each selected element to the next free destination slot. It then clears the rest of the destination up to the maximum element count, one element per cycle. When it finishes, it raises `done` for one cycle. The result stays on `dst_out` until the next accepted start.

The maximum element count is VLEN >> mlen_log2. The legality check compares the destination register number with the source register number. It also checks whether the mask register falls inside the destination register group. An illegal request changes nothing. It completes at once with the illegal flag set.

Top module: `vcompress_unit`

## Requirements
- R1: For each index i from 0 to vl-1 in rising order, a set mask bit copies source element i into destination element num and then increments num; a clear mask bit skips the element, so the selected elements keep their relative order.
- R2: `sew_sel` encodes the element width as 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits; element k occupies bits [k*SEW +: SEW] of both the source and the destination group.
- R3: The mask bit for element i is bit (i << mlen_log2) of `mask_reg`. The maximum element count is VLMAX = VLEN >> mlen_log2. A `vl` larger than VLMAX is treated as VLMAX.
- R4: After packing, destination elements num through VLMAX-1 read as zero.
- R5: With `vl` equal to 0 and a legal request, `dst_out` equals `dst_old` and `done` rises in the cycle after the start edge.
- R6: Destination bits at or above VLMAX*SEW keep the value captured from `dst_old`.
- R7: For a legal request with vl > 0, `done` is high for exactly one cycle, and the number of clock edges from the start edge to the edge that raises it is vl + (VLMAX - num). `busy` is high from the start edge until that edge.
- R8: A `start` pulse while `busy` is high is ignored, and the running operation finishes with its original operands.
- R9: When `rd_idx` equals `vs_idx`, `illegal` is set, `dst_out` equals `dst_old`, and `done` rises in the cycle after the start edge.
- R10: When `ms_idx` lies in [rd_idx, rd_idx + 2^lmul_log2), `illegal` is set with the same effect as in R9. A mask register just past the group is legal.
- R11: After reset, `busy`, `done` and `illegal` are low and `dst_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; operands are captured on this edge when idle |
| sew_sel | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64) |
| mlen_log2 | input | 3 | log2 of the mask-element spacing |
| lmul_log2 | input | 2 | log2 of the destination group size in registers |
| vl | input | 7 | Active element count |
| rd_idx | input | 5 | Destination register number |
| ms_idx | input | 5 | Mask register number |
| vs_idx | input | 5 | Source register number |
| src_grp | input | 512 | Source register group |
| mask_reg | input | 64 | Mask register contents |
| dst_old | input | 512 | Destination group contents before the operation |
| dst_out | output | 512 | Destination group result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last accepted request failed the register check |

## Verification
The hardest situation to reach from the ports is a start pulse that arrives in the middle of a run. The bench raises `start` a few cycles into a long operation and drives completely different operands at the same moment. It then checks that the result and the completion timing still follow the first request. Two other corners get dedicated cases. One has an all-zero mask, so the whole range from 0 to VLMAX is cleared by the tail. The other uses a wide mask spacing, so VLMAX*SEW ends well below the top of the group and the upper bits must survive.

// File: rtl/vcu_pkg.sv
package vcu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PACK = 2'd1,
    ST_TAIL = 2'd2
  } vcu_state_e;
endpackage

// File: rtl/vcu_legal.sv
module vcu_legal #(
  parameter int RIDW = 5
) (
  input  logic [RIDW-1:0] rd_idx,
  input  logic [RIDW-1:0] ms_idx,
  input  logic [RIDW-1:0] vs_idx,
  input  logic [1:0]      lmul_log2,
  output logic            illegal
);
  logic [RIDW:0] grp_end;
  logic          same_src;
  logic          mask_in_grp;

  always_comb begin
    grp_end     = {1'b0, rd_idx} + ((RIDW+1)'(1) << lmul_log2);
    same_src    = (rd_idx == vs_idx);
    mask_in_grp = (ms_idx >= rd_idx) && ({1'b0, ms_idx} < grp_end);
    illegal     = same_src || mask_in_grp;
  end
endmodule

// File: rtl/vcu_ctrl.sv
module vcu_ctrl
  import vcu_pkg::*;
#(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          go,
  input  logic [IW-1:0] vl_in,
  input  logic [IW-1:0] vlmax_in,
  input  logic          mask_bit,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] num,
  output logic          wr_en,
  output logic          wr_zero
);
  vcu_state_e    state_q;
  logic [IW-1:0] idx_q, num_q, vl_q, vlmax_q;
  logic          done_q;
  logic [IW-1:0] num_nx;
  logic          last_idx;

  always_comb begin
    num_nx   = num_q + IW'(mask_bit);
    last_idx = (idx_q == vl_q - IW'(1));
    wr_en    = 1'b0;
    wr_zero  = 1'b0;
    if (state_q == ST_PACK) wr_en = mask_bit;
    if (state_q == ST_TAIL) begin
      wr_en   = 1'b1;
      wr_zero = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      num_q   <= '0;
      vl_q    <= '0;
      vlmax_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (launch) begin
          vl_q    <= vl_in;
          vlmax_q <= vlmax_in;
          idx_q   <= '0;
          num_q   <= '0;
          if (go) state_q <= ST_PACK;
          else    done_q  <= 1'b1;
        end
        ST_PACK: begin
          idx_q <= idx_q + IW'(1);
          num_q <= num_nx;
          if (last_idx) begin
            if (num_nx < vlmax_q) state_q <= ST_TAIL;
            else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_TAIL: begin
          num_q <= num_q + IW'(1);
          if (num_q == vlmax_q - IW'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign idx  = idx_q;
  assign num  = num_q;

  // R4
  num_bound_chk: assert property (@(posedge clk) disable iff (rst)
    num_q <= vlmax_q);
  // R1
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PACK) |-> (idx_q < vl_q));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (state_q == ST_IDLE));
  // R8
  hold_op_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(vlmax_q) && $stable(vl_q));
endmodule

// File: rtl/vcu_datapath.sv
module vcu_datapath #(
  parameter int VLEN = 64,
  parameter int GRP  = 512,
  parameter int IW   = 7,
  parameter int MLW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           launch,
  input  logic [GRP-1:0] src_in,
  input  logic [VLEN-1:0] mask_in,
  input  logic [GRP-1:0] old_in,
  input  logic [1:0]     sew_in,
  input  logic [MLW-1:0] ml_in,
  input  logic [IW-1:0]  idx,
  input  logic [IW-1:0]  num,
  input  logic           wr_en,
  input  logic           wr_zero,
  output logic           mask_bit,
  output logic [GRP-1:0] dst
);
  localparam int POSW = $clog2(VLEN * 64) + 2;
  localparam int MAW  = (VLEN > 1) ? $clog2(VLEN) : 1;

  logic [GRP-1:0]  src_q, dst_q;
  logic [VLEN-1:0] mask_q;
  logic [1:0]      sew_q;
  logic [MLW-1:0]  ml_q;

  logic [POSW-1:0] sew_w, src_pos, dst_pos, mpos;
  logic [63:0]     emask, elem;
  logic [GRP-1:0]  ext, wmask, wval;
  logic            fits;

  always_comb begin
    sew_w   = POSW'(8) << sew_q;
    src_pos = POSW'(idx) * sew_w;
    dst_pos = POSW'(num) * sew_w;
    fits    = (dst_pos + sew_w) <= POSW'(GRP);
    case (sew_q)
      2'd0:    emask = 64'h0000_0000_0000_00FF;
      2'd1:    emask = 64'h0000_0000_0000_FFFF;
      2'd2:    emask = 64'h0000_0000_FFFF_FFFF;
      default: emask = '1;
    endcase
    ext      = src_q >> src_pos;
    elem     = ext[63:0] & emask;
    mpos     = POSW'(idx) << ml_q;
    mask_bit = (mpos < POSW'(VLEN)) ? mask_q[mpos[MAW-1:0]] : 1'b0;
    wmask    = GRP'(emask) << dst_pos;
    wval     = wr_zero ? '0 : (GRP'(elem) << dst_pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      mask_q <= '0;
      sew_q  <= '0;
      ml_q   <= '0;
    end else if (launch) begin
      src_q  <= src_in;
      dst_q  <= old_in;
      mask_q <= mask_in;
      sew_q  <= sew_in;
      ml_q   <= ml_in;
    end else if (wr_en && fits) begin
      dst_q <= (dst_q & ~wmask) | wval;
    end
  end

  assign dst = dst_q;

  // R6
  dst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !launch) |=> $stable(dst_q));
endmodule

// File: rtl/vcompress_unit.sv
module vcompress_unit #(
  parameter int VLEN     = 64,
  parameter int MAX_LMUL = 8,
  parameter int RIDW     = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [1:0]               sew_sel,
  input  logic [2:0]               mlen_log2,
  input  logic [1:0]               lmul_log2,
  input  logic [$clog2(VLEN+1)-1:0] vl,
  input  logic [RIDW-1:0]          rd_idx,
  input  logic [RIDW-1:0]          ms_idx,
  input  logic [RIDW-1:0]          vs_idx,
  input  logic [VLEN*MAX_LMUL-1:0] src_grp,
  input  logic [VLEN-1:0]          mask_reg,
  input  logic [VLEN*MAX_LMUL-1:0] dst_old,
  output logic [VLEN*MAX_LMUL-1:0] dst_out,
  output logic                     busy,
  output logic                     done,
  output logic                     illegal
);
  localparam int GRP = VLEN * MAX_LMUL;
  localparam int IW  = $clog2(VLEN + 1);

  logic          ill_c, ill_q, launch, go, mask_bit, wr_en, wr_zero;
  logic [IW-1:0] vlmax_c, vl_eff, idx, num;

  always_comb begin
    vlmax_c = IW'(VLEN) >> mlen_log2;
    if (vlmax_c == '0) vlmax_c = IW'(1);
    vl_eff = (vl > vlmax_c) ? vlmax_c : vl;
    launch = start && !busy;
    go     = !ill_c && (vl_eff != '0);
  end

  vcu_legal #(.RIDW(RIDW)) u_legal (
    .rd_idx(rd_idx), .ms_idx(ms_idx), .vs_idx(vs_idx),
    .lmul_log2(lmul_log2), .illegal(ill_c)
  );

  vcu_ctrl #(.IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .launch(launch), .go(go),
    .vl_in(vl_eff), .vlmax_in(vlmax_c), .mask_bit(mask_bit),
    .busy(busy), .done(done), .idx(idx), .num(num),
    .wr_en(wr_en), .wr_zero(wr_zero)
  );

  vcu_datapath #(.VLEN(VLEN), .GRP(GRP), .IW(IW), .MLW(3)) u_dp (
    .clk(clk), .rst(rst), .launch(launch),
    .src_in(src_grp), .mask_in(mask_reg), .old_in(dst_old),
    .sew_in(sew_sel), .ml_in(mlen_log2),
    .idx(idx), .num(num), .wr_en(wr_en), .wr_zero(wr_zero),
    .mask_bit(mask_bit), .dst(dst_out)
  );

  always_ff @(posedge clk) begin
    if (rst)         ill_q <= 1'b0;
    else if (launch) ill_q <= ill_c;
  end

  assign illegal = ill_q;

  // R9
  ill_no_run_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !busy);
  // R10
  ill_done_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && ill_c) |=> done);
endmodule

// File: tb/vcompress_unit_test.sv
module vcompress_unit_test;
  localparam int VLEN = 64;
  localparam int GRP  = 512;

  logic           clk = 0, rst = 1, start = 0;
  logic [1:0]     sew_sel = 0, lmul_log2 = 0;
  logic [2:0]     mlen_log2 = 0;
  logic [6:0]     vl = 0;
  logic [4:0]     rd_idx = 0, ms_idx = 0, vs_idx = 0;
  logic [GRP-1:0] src_grp = 0, dst_old = 0;
  logic [VLEN-1:0] mask_reg = 0;
  logic [GRP-1:0] dst_out;
  logic           busy, done, illegal;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  vcompress_unit uut (
    .clk(clk), .rst(rst), .start(start), .sew_sel(sew_sel),
    .mlen_log2(mlen_log2), .lmul_log2(lmul_log2), .vl(vl),
    .rd_idx(rd_idx), .ms_idx(ms_idx), .vs_idx(vs_idx),
    .src_grp(src_grp), .mask_reg(mask_reg), .dst_old(dst_old),
    .dst_out(dst_out), .busy(busy), .done(done), .illegal(illegal)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [GRP-1:0] act, input logic [GRP-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [GRP-1:0] rand_grp();
    logic [GRP-1:0] v;
    for (int w = 0; w < GRP/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // Runs one request; when disturb is set, a second start with other
  // operands is pulsed while the first operation is busy.
  task automatic run(input string req, input int sew_c, input int ml,
                     input int lm, input int vlen_a, input int rd,
                     input int ms, input int vs, input logic [GRP-1:0] src,
                     input logic [VLEN-1:0] msk, input logic [GRP-1:0] old,
                     input bit disturb);
    int sew = 8 << sew_c;
    int vlmax = VLEN >> ml;
    int vle = (vlen_a > vlmax) ? vlmax : vlen_a;
    bit ill = (rd == vs) || (ms >= rd && ms < rd + (1 << lm));
    logic [GRP-1:0] exp = old;
    int cnt = 0;
    int lat;
    bit tim_ok = 1;
    if (!ill && vle > 0) begin
      for (int i = 0; i < vle; i++)
        if (msk[i << ml]) begin
          for (int b = 0; b < sew; b++)
            if (cnt*sew + b < GRP) exp[cnt*sew + b] = src[i*sew + b];
          cnt++;
        end
      for (int k = cnt; k < vlmax; k++)
        for (int b = 0; b < sew; b++)
          if (k*sew + b < GRP) exp[k*sew + b] = 1'b0;
      lat = vle + (vlmax - cnt);
    end else lat = 0;

    @(negedge clk);
    sew_sel = 2'(sew_c); mlen_log2 = 3'(ml); lmul_log2 = 2'(lm);
    vl = 7'(vlen_a); rd_idx = 5'(rd); ms_idx = 5'(ms); vs_idx = 5'(vs);
    src_grp = src; mask_reg = msk; dst_old = old; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k <= lat; k++) begin
      if (done !== (k == lat) || busy !== (k < lat)) tim_ok = 0;
      if (disturb && k == 2 && lat > 4) begin
        start = 1; src_grp = ~src; mask_reg = ~msk; vl = 7'd1;
        dst_old = '1; rd_idx = 5'(vs);
      end else start = 0;
      if (k < lat) @(negedge clk);
    end
    start = 0;
    check(tim_ok, req, "done/busy timing", GRP'(lat), GRP'(lat));
    check(dst_out === exp, req, "dst_out", dst_out, exp);
    check(illegal === ill, req, "illegal", GRP'(illegal), GRP'(ill));
    @(negedge clk);
    check(done === 1'b0, req, "done single pulse", GRP'(done), '0);
  endtask

  initial begin
    logic [GRP-1:0] s, o;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    check(busy === 0 && done === 0 && illegal === 0, "R11", "ctrl flags",
          GRP'({busy, done, illegal}), '0);
    check(dst_out === '0, "R11", "dst_out", dst_out, '0);

    // R1 R2 8-bit, alternating mask, full VLMAX
    s = rand_grp(); o = rand_grp();
    run("R1", 0, 0, 3, 64, 8, 0, 16, s, 64'hAAAA_5555_F0F0_0FF0, o, 0);
    // R2 R4 16-bit with tail
    s = rand_grp(); o = rand_grp();
    run("R2", 1, 1, 2, 10, 4, 1, 12, s, 64'h0000_0000_0000_0A5D, o, 0);
    // R7 R3 32-bit all selected, no tail; vl clamped to VLMAX
    s = rand_grp(); o = rand_grp();
    run("R7", 2, 2, 1, 40, 2, 0, 6, s, '1, o, 0);
    // R4 64-bit, empty mask: whole range cleared by tail
    s = rand_grp(); o = rand_grp();
    run("R4", 3, 3, 0, 5, 2, 0, 6, s, '0, o, 0);
    // R3 mask spacing with bits outside stride set
    s = rand_grp(); o = rand_grp();
    run("R3", 1, 2, 1, 16, 2, 0, 6, s, 64'h6666_6666_1111_1101, o, 0);
    // R5 vl zero leaves destination alone
    s = rand_grp(); o = rand_grp();
    run("R5", 0, 0, 0, 0, 2, 0, 6, s, '1, o, 0);
    // R6 bits above VLMAX*SEW kept (8-bit, VLMAX 8)
    s = rand_grp(); o = rand_grp();
    run("R6", 0, 3, 0, 8, 2, 0, 6, s, 64'h0101_0000_0100_0101, o, 0);
    // R9 destination equals source register
    s = rand_grp(); o = rand_grp();
    run("R9", 1, 1, 0, 12, 7, 0, 7, s, '1, o, 0);
    // R10 mask register inside destination group
    s = rand_grp(); o = rand_grp();
    run("R10", 0, 0, 2, 20, 8, 10, 20, s, '1, o, 0);
    // R10 mask register just past the group is legal
    s = rand_grp(); o = rand_grp();
    run("R10", 0, 0, 2, 20, 8, 12, 20, s, 64'h0F0F_0F0F_0F0F_0F0F, o, 0);
    // R8 start during a run is ignored
    s = rand_grp(); o = rand_grp();
    run("R8", 0, 1, 2, 30, 4, 1, 12, s, 64'h1234_5678_9ABC_DEF1, o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule